// File: doc/BRIEF.md
# Board Interrupt Level Encoder

This block gathers thirteen level-sensitive peripheral interrupt lines, places each on its own bit of a 16-bit monitor word, gates that word with a software-written enable mask and reduces what is left to a single 4-bit interrupt level for the CPU. Each source carries a fixed priority number. The smallest number among the enabled, active sources wins, and the winning number is inverted (XOR 15) before it leaves the block. The output is therefore 0 when nothing is pending and 15 for the most urgent source.

A small 16-bit register bus sits beside the encoder. It holds the enable mask, a general-purpose output word that drives a parallel output bus, a fixed version word and a power-off control. A write to the power-off control with bit 0 set produces a one-cycle shutdown pulse. All registers clear on reset, so every source starts masked and the level output starts at 0.

Top module: `brd_irl_ctrl`

## Requirements
- R1: Each `src_i` index maps to a fixed (monitor bit, priority) pair: 0→(9,1), 1→(8,2), 2→(14,9), 3→(13,10), 4→(12,3), 5→(11,0), 6→(10,4), 7→(6,5), 8→(5,6), 9→(4,7), 10→(7,8), 11→(0,11), 12→(15,12). Monitor bits 1 to 3 are always 0, and the monitor follows the current source levels.
- R2: A source is pending only when its input is high and the mask register bit at its monitor bit position is 1.
- R3: When several sources are pending, the one with the smallest priority number sets the level.
- R4: `irl_o` equals the winning priority XOR 15. With nothing pending it is 0, so priority 0 gives 15.
- R5: `irl_o` is registered. It reflects `src_i` sampled at the previous rising edge and the mask value held during that cycle, so a mask write shows on `irl_o` one edge after the mask register takes the write.
- R6: Byte offset 0x00 is the mask register, read/write across all 16 bits.
- R7: Byte offset 0x36 is the output-port register, read/write, and its value drives `gpo_o` from the edge after the write.
- R8: Byte offset 0x32 reads 0x0010. Writes to it change nothing.
- R9: Byte offset 0x30 reads 0. A write with `bus_wdata_i[0]`=1 makes `shutdown_o` high for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R10: Reads from any other offset return 0. Writes to any other offset leave the mask, the output port and `irl_o` unchanged.
- R11: After reset the mask, the output port, `bus_rdata_o`, `shutdown_o` and `irl_o` are all 0.
- R12: A read (`bus_req_i`=1, `bus_we_i`=0) puts its data on `bus_rdata_o` at the next rising edge, and the data stays there until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 13 | Peripheral interrupt levels, synchronous to clk_i |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset in the register window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after a read strobe |
| irl_o | output | 4 | Encoded interrupt level (winning priority XOR 15) |
| gpo_o | output | 16 | General-purpose output word |
| shutdown_o | output | 1 | One-cycle power-off request |

## Verification
Source changes show on `irl_o` at the first rising edge after they are applied. A mask write lands in the register at its own edge and shows on `irl_o` one edge later. Read data and the shutdown pulse each appear at the edge that samples the strobe. The bench drives inputs on the falling edge and samples on a later falling edge that counts exactly those registers. It also checks `irl_o` in the gap between a mask write and its effect, to show the extra cycle is really there.

// File: rtl/brd_irl_pkg.sv
package brd_irl_pkg;
  localparam int unsigned NSRC = 13;
  localparam int unsigned DW   = 16;
  localparam int unsigned AW   = 6;
  localparam int unsigned LW   = 4;

  localparam logic [AW-1:0] OFF_MASK = 6'h00;
  localparam logic [AW-1:0] OFF_PWR  = 6'h30;
  localparam logic [AW-1:0] OFF_VER  = 6'h32;
  localparam logic [AW-1:0] OFF_GPO  = 6'h36;
  localparam logic [DW-1:0] VER_VAL  = 16'h0010;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_PWR, SEL_VER, SEL_GPO
  } reg_sel_e;

  // monitor bit owned by each source index
  function automatic logic [3:0] src_bit(input int unsigned idx);
    case (idx)
      0: return 4'd9;   1: return 4'd8;   2: return 4'd14;  3: return 4'd13;
      4: return 4'd12;  5: return 4'd11;  6: return 4'd10;  7: return 4'd6;
      8: return 4'd5;   9: return 4'd4;   10: return 4'd7;  11: return 4'd0;
      12: return 4'd15;
      default: return 4'd1;
    endcase
  endfunction

  // priority number of each source index, lower wins
  function automatic logic [LW-1:0] src_prio(input int unsigned idx);
    case (idx)
      0: return 4'd1;   1: return 4'd2;   2: return 4'd9;   3: return 4'd10;
      4: return 4'd3;   5: return 4'd0;   6: return 4'd4;   7: return 4'd5;
      8: return 4'd6;   9: return 4'd7;   10: return 4'd8;  11: return 4'd11;
      12: return 4'd12;
      default: return 4'd15;
    endcase
  endfunction

  function automatic reg_sel_e decode(input logic [AW-1:0] addr);
    case (addr)
      OFF_MASK: return SEL_MASK;
      OFF_PWR:  return SEL_PWR;
      OFF_VER:  return SEL_VER;
      OFF_GPO:  return SEL_GPO;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/brd_irl_monitor.sv
module brd_irl_monitor
  import brd_irl_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned MON_W = DW
) (
  input  logic [N_SRC-1:0] src_i,
  output logic [MON_W-1:0] mon_o
);
  always_comb begin
    mon_o = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      mon_o[src_bit(i)] = src_i[i];
    end
  end
endmodule

// File: rtl/brd_irl_encoder.sv
module brd_irl_encoder
  import brd_irl_pkg::*;
#(
  parameter int unsigned N_SRC = NSRC,
  parameter int unsigned MON_W = DW,
  parameter int unsigned LVL_W = LW
) (
  input  logic [MON_W-1:0] mon_i,
  input  logic [MON_W-1:0] mask_i,
  output logic [LVL_W-1:0] code_o
);
  localparam logic [LVL_W-1:0] IDLE_LVL = '1;

  logic [MON_W-1:0] pend;
  logic [N_SRC-1:0] src_pend;
  logic [LVL_W-1:0] best;

  assign pend = mon_i & mask_i;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_pend[g] = pend[src_bit(g)];
  end

  always_comb begin
    best = IDLE_LVL;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      if (src_pend[i] && (src_prio(i) < best)) best = src_prio(i);
    end
  end

  // idle level inverts to 0
  assign code_o = best ^ IDLE_LVL;
endmodule

// File: rtl/brd_irl_regs.sv
module brd_irl_regs
  import brd_irl_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] gpo_o,
  output logic              shut_o
);
  reg_sel_e          sel;
  logic              wr, rd;
  logic [DATA_W-1:0] mask_q, gpo_q, rdata_q, rd_mux;
  logic              shut_q;

  assign sel = decode(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;

  always_comb begin
    case (sel)
      SEL_MASK: rd_mux = mask_q;
      SEL_VER:  rd_mux = VER_VAL;
      SEL_GPO:  rd_mux = gpo_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      gpo_q   <= '0;
      rdata_q <= '0;
      shut_q  <= 1'b0;
    end else begin
      shut_q <= wr && (sel == SEL_PWR) && wdata_i[0];
      if (wr && sel == SEL_MASK) mask_q <= wdata_i;
      if (wr && sel == SEL_GPO)  gpo_q  <= wdata_i;
      if (rd)                    rdata_q <= rd_mux;
    end
  end

  assign rdata_o = rdata_q;
  assign mask_o  = mask_q;
  assign gpo_o   = gpo_q;
  assign shut_o  = shut_q;
endmodule

// File: rtl/brd_irl_ctrl.sv
module brd_irl_ctrl
  import brd_irl_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_req_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic [LW-1:0]   irl_o,
  output logic [DW-1:0]   gpo_o,
  output logic            shutdown_o
);
  logic [DW-1:0] mon, mask_q;
  logic [LW-1:0] code, irl_q;

  brd_irl_monitor #(.N_SRC(NSRC), .MON_W(DW)) u_mon (
    .src_i (src_i),
    .mon_o (mon)
  );

  brd_irl_regs #(.DATA_W(DW), .ADDR_W(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .mask_o  (mask_q),
    .gpo_o   (gpo_o),
    .shut_o  (shutdown_o)
  );

  brd_irl_encoder #(.N_SRC(NSRC), .MON_W(DW), .LVL_W(LW)) u_enc (
    .mon_i  (mon),
    .mask_i (mask_q),
    .code_o (code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irl_q <= '0;
    else         irl_q <= code;
  end

  assign irl_o = irl_q;
endmodule

// File: rtl/brd_irl_ctrl_chk.sv
module brd_irl_ctrl_chk
  import brd_irl_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [NSRC-1:0] src_i,
  input logic            bus_req_i,
  input logic            bus_we_i,
  input logic [AW-1:0]   bus_addr_i,
  input logic [DW-1:0]   bus_wdata_i,
  input logic [DW-1:0]   bus_rdata_o,
  input logic [LW-1:0]   irl_o,
  input logic [DW-1:0]   gpo_o,
  input logic            shutdown_o,
  input logic [DW-1:0]   mask_i
);
  a_r4_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0) |=> (irl_o == '0));

  a_r3_top_prio_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i[5] && mask_i[11]) |=> (irl_o == 4'hF));

  a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |=> (irl_o == '0));

  a_r8_version_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i && bus_addr_i == OFF_VER) |=> (bus_rdata_o == VER_VAL));

  a_r7_gpo_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == OFF_GPO) |=> (gpo_o == $past(bus_wdata_i)));

  a_r10_gpo_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i && bus_addr_i == OFF_GPO) |=> $stable(gpo_o));

  a_r9_shutdown_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && bus_we_i && bus_addr_i == OFF_PWR && bus_wdata_i[0]) |=> shutdown_o);

  a_r9_no_spurious_shutdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && bus_we_i && bus_addr_i == OFF_PWR && bus_wdata_i[0]) |=> !shutdown_o);

  a_r12_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_i && !bus_we_i) |=> $stable(bus_rdata_o));
endmodule

bind brd_irl_ctrl brd_irl_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_i       (src_i),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irl_o       (irl_o),
  .gpo_o       (gpo_o),
  .shutdown_o  (shutdown_o),
  .mask_i      (mask_q)
);

// File: tb/brd_irl_ctrl_tb_top.sv
`timescale 1ns/1ps
module brd_irl_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, gpo;
  logic [3:0]  irl;
  logic        shut;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] cur_mask = '0;

  int tb_bit  [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
  int tb_prio [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};

  always #2 clk = ~clk;

  brd_irl_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irl_o(irl), .gpo_o(gpo), .shutdown_o(shut)
  );

  function automatic logic [3:0] exp_irl(logic [12:0] s, logic [15:0] m);
    int best = 15;
    for (int i = 0; i < 13; i++)
      if (s[i] && m[tb_bit[i]] && tb_prio[i] < best) best = tb_prio[i];
    return 4'(best) ^ 4'hF;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == 6'h00) cur_mask = d;
  endtask

  task automatic bus_rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0; d = rdata;
  endtask

  task automatic set_src(logic [12:0] s);
    @(negedge clk); src = s;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 irl", 16'(irl), 0);
    check("R11 gpo", gpo, 0);
    check("R11 rdata", rdata, 0);
    check("R11 shutdown", 16'(shut), 0);
    set_src('1);
    check("R11 mask clear gives irl 0", 16'(irl), 0);
    set_src('0);
  endtask

  task automatic t_single_sources;
    logic [15:0] d;
    bus_wr(6'h00, 16'hFFFF);
    for (int i = 0; i < 13; i++) begin
      set_src(13'(1) << i);
      check($sformatf("R1 R4 src %0d", i), 16'(irl), 16'(tb_prio[i] ^ 15));
    end
    // mask only the owning bit for each source
    for (int i = 0; i < 13; i++) begin
      bus_wr(6'h00, ~(16'(1) << tb_bit[i]));
      set_src(13'(1) << i);
      check($sformatf("R2 masked src %0d", i), 16'(irl), 0);
    end
    bus_wr(6'h00, 16'h000E);
    set_src('1);
    check("R1 unused bits 1-3", 16'(irl), 0);
    bus_rd(6'h00, d);
    check("R6 mask readback", d, 16'h000E);
  endtask

  task automatic t_priority;
    logic [15:0] lfsr = 16'hACE1;
    bus_wr(6'h00, 16'hFFFF);
    set_src('1);
    check("R3 all pending -> 15", 16'(irl), 16'hF);
    set_src(13'h1FDF);
    check("R3 drop top -> 14", 16'(irl), 16'hE);
    set_src(13'h1804);
    check("R3 pair 9 vs 11", 16'(irl), 16'(9 ^ 15));
    for (int k = 0; k < 40; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bus_wr(6'h00, lfsr ^ 16'h5A3C);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      set_src(lfsr[12:0]);
      check("R2 R3 R4 pattern", 16'(irl), 16'(exp_irl(src, cur_mask)));
    end
  endtask

  task automatic t_latency;
    bus_wr(6'h00, 16'h0000);
    set_src(13'h0020);
    check("R5 masked before", 16'(irl), 0);
    @(negedge clk); req = 1; we = 1; addr = 6'h00; wdata = 16'h0800;
    @(negedge clk); req = 0; we = 0; cur_mask = 16'h0800;
    check("R5 not yet after mask write", 16'(irl), 0);
    @(negedge clk);
    check("R5 one edge after mask", 16'(irl), 16'hF);
    @(negedge clk); src = 13'h0000;
    @(negedge clk);
    check("R5 source drop next edge", 16'(irl), 0);
  endtask

  task automatic t_registers;
    logic [15:0] d;
    bus_wr(6'h36, 16'hBEEF);
    check("R7 gpo drive", gpo, 16'hBEEF);
    bus_rd(6'h36, d);
    check("R7 gpo readback", d, 16'hBEEF);
    bus_wr(6'h32, 16'hFFFF);
    bus_rd(6'h32, d);
    check("R8 version", d, 16'h0010);
    check("R12 rdata held", rdata, 16'h0010);
    repeat (3) @(negedge clk);
    check("R12 rdata still held", rdata, 16'h0010);
    bus_rd(6'h30, d);
    check("R9 power read 0", d, 0);
    @(negedge clk); req = 1; we = 1; addr = 6'h30; wdata = 16'h0001;
    @(negedge clk); req = 0; we = 0;
    check("R9 shutdown pulse", 16'(shut), 1);
    @(negedge clk);
    check("R9 pulse one cycle", 16'(shut), 0);
    @(negedge clk); req = 1; we = 1; addr = 6'h30; wdata = 16'hFFFE;
    @(negedge clk); req = 0; we = 0;
    check("R9 bit0 clear no pulse", 16'(shut), 0);
    bus_wr(6'h00, 16'hFFFF);
    set_src(13'h0001);
    bus_wr(6'h02, 16'h0000);
    bus_wr(6'h34, 16'h0000);
    bus_wr(6'h3E, 16'h1234);
    @(negedge clk);
    check("R10 irl unchanged", 16'(irl), 16'hE);
    check("R10 gpo unchanged", gpo, 16'hBEEF);
    bus_rd(6'h00, d);
    check("R10 mask unchanged", d, 16'hFFFF);
    bus_rd(6'h02, d);
    check("R10 unmapped read", d, 0);
    bus_rd(6'h38, d);
    check("R10 unmapped read 38", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single_sources();
    t_priority();
    t_latency();
    t_registers();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hang exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule